// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 128 interrupt lines and reduces them to two requests toward a processor core: a fast request and a normal request. Software sets up each line through a small word-addressed register bus. Each line has an enable bit, a type bit that steers it to the fast or the normal request, and a 4-bit priority level. A global level mask filters normal requests. Two read-only registers report the winning fast line and the winning normal line, so a handler can find its source without scanning.

Fast lines always rank above normal ones. Among fast lines, the highest-numbered pending line is reported. Among normal lines, the highest level wins, and a tie at the same level goes to the higher line number. Register writes take effect only when the privilege flag is set. Reads made without the flag return zero. The request outputs and the two winner registers are registered, so they lag their causes by one clock.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every line is disabled and of normal type with level 0, the mask is 0, both requests are low, and both winner registers read 0x0000007F.
- R2: Enable words live at word addresses 0 to 3. Bit b of word k enables line 32k+b, and the words read back what was written. Bits for lines at or above NSRC read as 0.
- R3: An enabled, asserted normal line whose level passes the mask raises `irq` exactly one clock edge after the line changes. A disabled line has no effect.
- R4: Type words live at word addresses 4 to 7 and use the same bit layout as the enable words. A type bit of 1 routes the line to `fiq` only. Such a line never appears as a normal winner.
- R5: The fast winner register (address 11) reports the highest-numbered enabled, asserted fast line in bits 6:0, with bit 31 set. When no fast line is pending it reads 0x7F with bit 31 clear.
- R6: Writing a line number to address 8 sets that line's enable bit, and writing it to address 9 clears it. No other enable bit changes, and a number at or above NSRC changes nothing.
- R7: The normal winner register (address 12, same format as R5) reports the pending normal line with the highest level. Among lines at equal level, the higher line number wins.
- R8: The mask register at address 10 (bits 3:0) passes a normal line only when its level is strictly above the mask. With mask 0, lines at level 0 never raise `irq`.
- R9: Priority words live at addresses 16 to 31. Word 16+k holds lines 8k to 8k+7, with 4 bits per line and line 8k in bits 3:0, and the words read back as written.
- R10: A write with `priv` low changes no register. A read with `priv` low returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | NSRC | Interrupt lines, already synchronous to clk |
| addr | input | 6 | Register word address |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| priv | input | 1 | Supervisor privilege flag for the access |
| rdata | output | 32 | Read data, valid while rd is high |
| fiq | output | 1 | Fast interrupt request |
| irq | output | 1 | Normal interrupt request |

## Verification
The bench runs a 16-line configuration. It steps a single asserted line through every level, then sweeps the mask across all 16 values with every line asserted. A design that tested the mask with greater-or-equal would let level-0 lines through and would keep reporting line 15 at mask 15. A tie-break that favoured the lower index would show up in the long pseudo-random run, where some rounds force every level equal. A fast line leaking into the normal search would be reported as the normal winner, and a write that ignored `priv` would be caught by readback. A one-cycle check around a line edge exposes an unregistered request or an extra pipeline stage.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [5:0]      addr,
  input  logic [31:0]     wdata,
  input  logic            wr,
  input  logic            rd,
  input  logic            priv,
  output logic [31:0]     rdata,
  output logic            fiq,
  output logic            irq
);
  localparam logic [5:0] A_EN     = 6'd0;
  localparam logic [5:0] A_TYPE   = 6'd4;
  localparam logic [5:0] A_ENNUM  = 6'd8;
  localparam logic [5:0] A_DISNUM = 6'd9;
  localparam logic [5:0] A_MASK   = 6'd10;
  localparam logic [5:0] A_FPEND  = 6'd11;
  localparam logic [5:0] A_NPEND  = 6'd12;
  localparam logic [5:0] A_PRIO   = 6'd16;
  localparam logic [6:0] NONE     = 7'h7F;

  logic [NSRC-1:0]   en, ty;
  logic [4*NSRC-1:0] lv;
  logic [3:0]        mask;
  logic              fv, nv, fv_q, nv_q;
  logic [6:0]        fn, nn, fn_q, nn_q;
  logic [3:0]        nl;

  wire wen = wr & priv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en   <= '0;
      ty   <= '0;
      lv   <= '0;
      mask <= '0;
    end else if (wen) begin
      if (addr == A_MASK) mask <= wdata[3:0];
      for (int i = 0; i < NSRC; i++) begin
        if (addr == A_EN + 6'(i / 32))   en[i] <= wdata[i % 32];
        if (addr == A_ENNUM  && wdata[6:0] == 7'(i)) en[i] <= 1'b1;
        if (addr == A_DISNUM && wdata[6:0] == 7'(i)) en[i] <= 1'b0;
        if (addr == A_TYPE + 6'(i / 32)) ty[i] <= wdata[i % 32];
        if (addr == A_PRIO + 6'(i / 8))  lv[4*i +: 4] <= wdata[4*(i % 8) +: 4];
      end
    end

  always_comb begin
    fv = 1'b0;
    fn = NONE;
    nv = 1'b0;
    nn = NONE;
    nl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src[i] && en[i] && ty[i]) begin
        fv = 1'b1;
        fn = 7'(i);
      end
      if (src[i] && en[i] && !ty[i] && lv[4*i +: 4] > mask &&
          (!nv || lv[4*i +: 4] >= nl)) begin
        nv = 1'b1;
        nn = 7'(i);
        nl = lv[4*i +: 4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fv_q <= 1'b0;
      nv_q <= 1'b0;
      fn_q <= NONE;
      nn_q <= NONE;
    end else begin
      fv_q <= fv;
      nv_q <= nv;
      fn_q <= fn;
      nn_q <= nn;
    end

  assign fiq = fv_q;
  assign irq = nv_q;

  always_comb begin
    rdata = '0;
    if (rd && priv) begin
      case (addr)
        A_MASK:  rdata[3:0] = mask;
        A_FPEND: rdata = {fv_q, 24'd0, fn_q};
        A_NPEND: rdata = {nv_q, 24'd0, nn_q};
        default: ;
      endcase
      for (int i = 0; i < NSRC; i++) begin
        if (addr == A_EN + 6'(i / 32))   rdata[i % 32] = en[i];
        if (addr == A_TYPE + 6'(i / 32)) rdata[i % 32] = ty[i];
        if (addr == A_PRIO + 6'(i / 8))  rdata[4*(i % 8) +: 4] = lv[4*i +: 4];
      end
    end
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int NSRC = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src,
  input logic [5:0]        addr,
  input logic [31:0]       wdata,
  input logic              wr,
  input logic              rd,
  input logic              priv,
  input logic [31:0]       rdata,
  input logic              fiq,
  input logic              irq,
  input logic [NSRC-1:0]   en,
  input logic [NSRC-1:0]   ty,
  input logic [4*NSRC-1:0] lv,
  input logic [3:0]        mask,
  input logic [6:0]        fn_q,
  input logic [6:0]        nn_q
);
  localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};

  a_r3_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(src & en & ~ty)));

  a_r4_fiq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> $past(|(src & en & ty)));

  a_r5_idle_fast_code: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq |-> fn_q == 7'h7F);

  a_r7_idle_norm_code: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> nn_q == 7'h7F);

  a_r6_set_by_number: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && priv && addr == 6'd8) |=> en == ($past(en) | (ONE << $past(wdata[6:0]))));

  a_r6_clear_by_number: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && priv && addr == 6'd9) |=> en == ($past(en) & ~(ONE << $past(wdata[6:0]))));

  a_r10_no_priv_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !priv) |=> ($stable(en) && $stable(ty) && $stable(lv) && $stable(mask)));

  a_r10_no_priv_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !priv) |-> rdata == 32'd0);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC)) chk (
  .clk(clk), .rst_n(rst_n), .src(src), .addr(addr), .wdata(wdata),
  .wr(wr), .rd(rd), .priv(priv), .rdata(rdata), .fiq(fiq), .irq(irq),
  .en(en), .ty(ty), .lv(lv), .mask(mask), .fn_q(fn_q), .nn_q(nn_q)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic [5:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic          wr = 1'b0, rd = 1'b0, priv = 1'b1;
  logic [31:0]   rdata;
  logic          fiq, irq;

  int n_cmp = 0, n_bad = 0;
  logic [NS-1:0] m_en = '0, m_ty = '0;
  logic [3:0]    m_lv [NS];
  logic [3:0]    m_mask = '0;
  logic [31:0]   d;
  logic [31:0]   rs = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NSRC(NS)) uut (
    .clk(clk), .rst_n(rst_n), .src(src), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .priv(priv), .rdata(rdata), .fiq(fiq), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [5:0] a, input logic [31:0] v, input logic p);
    @(negedge clk);
    addr = a; wdata = v; priv = p; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; priv = 1'b1;
  endtask

  task automatic rreg(input logic [5:0] a, input logic p, output logic [31:0] v);
    addr = a; priv = p; rd = 1'b1;
    #1 v = rdata;
    rd = 1'b0; priv = 1'b1;
  endtask

  function automatic logic [31:0] exp_fast();
    logic v = 1'b0;
    logic [6:0] n = 7'h7F;
    for (int i = 0; i < NS; i++)
      if (src[i] && m_en[i] && m_ty[i]) begin v = 1'b1; n = 7'(i); end
    return {v, 24'd0, n};
  endfunction

  function automatic logic [31:0] exp_norm();
    logic v = 1'b0;
    logic [6:0] n = 7'h7F;
    int best = -1;
    for (int i = 0; i < NS; i++)
      if (src[i] && m_en[i] && !m_ty[i] && int'(m_lv[i]) > int'(m_mask)
          && int'(m_lv[i]) >= best) begin
        v = 1'b1; n = 7'(i); best = int'(m_lv[i]);
      end
    return {v, 24'd0, n};
  endfunction

  function automatic logic [31:0] pack(input int b);
    logic [31:0] r = '0;
    for (int j = 0; j < 8; j++) r[4*j +: 4] = m_lv[b+j];
    return r;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic push_cfg();
    wreg(6'd0, {16'd0, m_en}, 1'b1);
    wreg(6'd4, {16'd0, m_ty}, 1'b1);
    wreg(6'd16, pack(0), 1'b1);
    wreg(6'd17, pack(8), 1'b1);
    wreg(6'd10, {28'd0, m_mask}, 1'b1);
  endtask

  task automatic settle(input string req);
    logic [31:0] ef, en_;
    @(posedge clk); @(posedge clk); @(negedge clk);
    ef = exp_fast(); en_ = exp_norm();
    chk({req, " fiq"}, {31'd0, fiq}, {31'd0, ef[31]});
    chk({req, " irq"}, {31'd0, irq}, {31'd0, en_[31]});
    rreg(6'd11, 1'b1, d); chk({req, " fast winner"}, d, ef);
    rreg(6'd12, 1'b1, d); chk({req, " normal winner"}, d, en_);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) m_lv[i] = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 fiq", {31'd0, fiq}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rreg(6'd11, 1'b1, d); chk("R1 fast winner", d, 32'h7F);
    rreg(6'd12, 1'b1, d); chk("R1 normal winner", d, 32'h7F);
    rreg(6'd10, 1'b1, d); chk("R1 mask", d, 32'd0);
    rreg(6'd0,  1'b1, d); chk("R1 enable", d, 32'd0);
    rreg(6'd4,  1'b1, d); chk("R1 type", d, 32'd0);
    rreg(6'd16, 1'b1, d); chk("R1 levels", d, 32'd0);

    wreg(6'd0, 32'hFFFF_A5A5, 1'b1);
    rreg(6'd0, 1'b1, d); chk("R2 enable readback", d, 32'h0000_A5A5);
    rreg(6'd1, 1'b1, d); chk("R2 absent word", d, 32'd0);

    for (int i = 0; i < NS; i++) m_lv[i] = 4'(i);
    wreg(6'd16, pack(0), 1'b1);
    wreg(6'd17, pack(8), 1'b1);
    rreg(6'd16, 1'b1, d); chk("R9 word 16", d, 32'h7654_3210);
    rreg(6'd17, 1'b1, d); chk("R9 word 17", d, 32'hFEDC_BA98);

    m_en = '1; m_ty = '0; m_mask = 4'd0;
    push_cfg();
    for (int s = 0; s < NS; s++) begin
      src = NS'(1) << s;
      settle("R9 single line");
      rreg(6'd12, 1'b1, d);
      chk("R9 R8 level by nibble", d, (s == 0) ? 32'h7F : {1'b1, 24'd0, 7'(s)});
    end

    src = '1;
    for (int m = 0; m < 16; m++) begin
      m_mask = 4'(m);
      wreg(6'd10, {28'd0, m_mask}, 1'b1);
      settle("R8 mask sweep");
      rreg(6'd12, 1'b1, d);
      chk("R8 mask winner", d, (m == 15) ? 32'h7F : {1'b1, 24'd0, 7'd15});
    end

    m_mask = 4'd0;
    wreg(6'd10, 32'd0, 1'b1);
    src = '0;
    settle("R3 idle");
    @(negedge clk);
    src = NS'(1) << 5;
    #1 chk("R3 before edge", {31'd0, irq}, 32'd0);
    @(posedge clk);
    #1 chk("R3 after one edge", {31'd0, irq}, 32'd1);
    wreg(6'd9, 32'd5, 1'b1);
    m_en[5] = 1'b0;
    settle("R3 disabled line");

    m_en[5] = 1'b1; m_ty[5] = 1'b1;
    push_cfg();
    src = (NS'(1) << 5) | (NS'(1) << 9) | (NS'(1) << 3);
    settle("R4 fast routing");
    rreg(6'd11, 1'b1, d); chk("R4 R5 fast winner", d, {1'b1, 24'd0, 7'd5});
    rreg(6'd12, 1'b1, d); chk("R4 normal excludes fast", d, {1'b1, 24'd0, 7'd9});
    m_ty[3] = 1'b1;
    wreg(6'd4, {16'd0, m_ty}, 1'b1);
    settle("R5 highest fast");

    wreg(6'd0, 32'd0, 1'b1);
    wreg(6'd8, 32'd5, 1'b1);
    wreg(6'd8, 32'd9, 1'b1);
    rreg(6'd0, 1'b1, d); chk("R6 set by number", d, 32'h0000_0220);
    wreg(6'd9, 32'd5, 1'b1);
    rreg(6'd0, 1'b1, d); chk("R6 clear by number", d, 32'h0000_0200);
    wreg(6'd8, 32'd100, 1'b1);
    rreg(6'd0, 1'b1, d); chk("R6 out of range", d, 32'h0000_0200);

    wreg(6'd0, 32'h0000_FFFF, 1'b0);
    rreg(6'd0, 1'b1, d); chk("R10 unprivileged enable write", d, 32'h0000_0200);
    wreg(6'd10, 32'd7, 1'b0);
    rreg(6'd10, 1'b1, d); chk("R10 unprivileged mask write", d, 32'd0);
    rreg(6'd0, 1'b0, d); chk("R10 unprivileged read", d, 32'd0);
    rreg(6'd17, 1'b0, d); chk("R10 unprivileged level read", d, 32'd0);

    for (int k = 0; k < 300; k++) begin
      if (k % 4 == 0) begin
        rs = nxt(rs); m_en = rs[15:0];
        rs = nxt(rs); m_ty = rs[15:0] & rs[31:16];
        rs = nxt(rs);
        for (int i = 0; i < 8; i++) m_lv[i] = rs[4*i +: 4];
        rs = nxt(rs);
        for (int i = 0; i < 8; i++) m_lv[i+8] = rs[4*i +: 4];
        if (k % 8 == 4)
          for (int i = 0; i < NS; i++) m_lv[i] = rs[3:0] | 4'd4;
        rs = nxt(rs); m_mask = {2'b00, rs[1:0]};
        push_cfg();
      end
      rs = nxt(rs);
      src = rs[NS-1:0];
      settle("R7 arbitration");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule